// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings an SDRAM device out of power-up and keeps its contents alive afterwards. Once reset is released and the clock-good input reports a stable clock, it takes the command bus and runs a fixed sequence. The sequence is a precharge of every bank, a burst of auto refreshes, one mode register load, and a second burst of auto refreshes. When that sequence ends it raises an init-done flag and hands the command bus to the access scheduler.

In normal operation a free-running interval timer marks a refresh as pending every refresh period. The default period is derived from a 125 MHz clock and a 15 µs target. For each pending refresh the sequencer asks the scheduler for the bus through a request/grant pair. After the grant it closes all banks, issues an auto refresh and then releases the bus.

A suspend input sends the device into self refresh. The block precharges all banks and then issues a refresh command in the same cycle that clock-enable falls. When suspend drops, clock-enable rises, an exit delay elapses, and one auto refresh is issued before the bus is returned.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: While reset is held or `clk_stable` is low, no command is issued: `cke` stays 0, `init_done` stays 0 and `bus_req` stays 0. During initialisation the bus shows NOP, which is `cs_n`=0 with `ras_n`,`cas_n`,`we_n` all 1.
- R2: Once `clk_stable` is seen high, the commands are issued in this order: one precharge-all, then `INIT_REFS` refreshes, then one mode register set, then `INIT_REFS` more refreshes. The spacing is `T_RP` cycles after the precharge, `T_RFC` after each refresh and `T_MRD` after the mode set. Pin encodings with `cs_n`=0 are as follows. Precharge-all is ras/cas/we = 0/1/0 with `addr[PRE_ALL_BIT]`=1. Refresh is 0/0/1. Mode set is 0/0/0 with `addr` = `MODE_VALUE`.
- R3: `init_done` rises exactly `T_RFC` cycles after the last refresh of initialisation and stays high until reset.
- R4: `bus_req` is never asserted before `init_done`. During initialisation the sequencer drives the bus without a grant.
- R5: After `init_done`, a refresh becomes pending every REFI = `CLK_MHZ`*`REFRESH_NS`/1000 cycles without drift. The first `bus_req` rises REFI+1 cycles after `init_done`, and each later request rises REFI cycles after the one before it, whatever the grant latency.
- R6: A refresh issues no command before `bus_gnt`. After the grant it issues a precharge-all, then a refresh `T_RP` cycles later. `bus_req` falls `T_RFC` cycles after that refresh, and no other command is issued in between.
- R7: With `suspend` high, the grant is followed by a precharge-all and, `T_RP` cycles later, a refresh in the same cycle that `cke` falls. After that, no command is issued and `cke` stays 0 while `suspend` is held.
- R8: When `suspend` falls, `cke` rises. A refresh follows `T_XSR` cycles later, and `bus_req` falls `T_RFC` cycles after that refresh.
- R9: `suspend` asserted during initialisation does not alter the init sequence. It takes effect only after `init_done`, when `bus_req` rises one cycle later.
- R10: When the sequencer does not own the bus (`bus_own`=0), it deselects the device with `cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_stable | input | 1 | Clock reported stable; starts initialisation |
| suspend | input | 1 | Request to hold the device in self refresh |
| bus_gnt | input | 1 | Command bus granted by the access scheduler |
| bus_req | output | 1 | Sequencer wants the command bus |
| bus_own | output | 1 | Sequencer is driving the command pins |
| init_done | output | 1 | Initialisation complete |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines |
| ba | output | BA_W | Bank address (always 0) |

## Verification
Every command pin, `cke`, `bus_req` and `init_done` is a register output. Each is therefore due on the clock edge where the sequencer makes its decision: one edge after a sampled `clk_stable`, `bus_gnt` or `suspend`, and exactly the wait parameter later for each timed step. The bench logs every command and every `bus_req`, `cke` and `init_done` edge on the falling clock edge, stamped with a cycle number. It then checks the differences between those stamps against `T_RP`, `T_RFC`, `T_MRD`, `T_XSR` and the refresh interval, computed from the parameters. Grant latency is swept from zero to four cycles, and one grant is held back for longer than a refresh period. Together these show that the request spacing does not follow the grant timing.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [2:0] {
        ST_CLKWAIT,
        ST_AFTER_PRE,
        ST_AFTER_REF,
        ST_AFTER_MRS,
        ST_IDLE,
        ST_REQ,
        ST_SELF,
        ST_EXIT_WAIT
    } state_e;

    typedef enum logic [2:0] {
        PH_INIT1,
        PH_INIT2,
        PH_AUTO,
        PH_SUSP,
        PH_EXIT
    } phase_e;

endpackage

// File: rtl/sdr_rfsh_timer.sv
module sdr_rfsh_timer #(
    parameter int unsigned INTERVAL = 1875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic pend
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) r_d.pend = 1'b0;
        if (!en) begin
            r_d.cnt = CW'(INTERVAL - 1);
        end else if (r_q.cnt == '0) begin
            r_d.cnt  = CW'(INTERVAL - 1);
            r_d.pend = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cnt  <= CW'(INTERVAL - 1);
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend = r_q.pend;
endmodule

// File: rtl/sdr_cmd_enc.sv
module sdr_cmd_enc
    import sdr_seq_pkg::*;
#(
    parameter int          ADDR_W      = 13,
    parameter int          BA_W        = 2,
    parameter int          PRE_ALL_BIT = 10,
    parameter int unsigned MODE_VALUE  = 32'h0033
) (
    input  cmd_e              cmd,
    input  logic              own,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    always_comb begin
        cs_n  = 1'b1;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        ba    = '0;
        if (own) begin
            cs_n = 1'b0;
            case (cmd)
                CMD_PRE: begin
                    ras_n             = 1'b0;
                    we_n              = 1'b0;
                    addr[PRE_ALL_BIT] = 1'b1;
                end
                CMD_REF: begin
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                end
                CMD_MRS: begin
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                    we_n  = 1'b0;
                    addr  = ADDR_W'(MODE_VALUE);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int          ADDR_W      = 13,
    parameter int          BA_W        = 2,
    parameter int          PRE_ALL_BIT = 10,
    parameter int unsigned MODE_VALUE  = 32'h0033,
    parameter int          INIT_REFS   = 8,
    parameter int          T_RP        = 3,
    parameter int          T_RFC       = 9,
    parameter int          T_MRD       = 2,
    parameter int          T_XSR       = 10,
    parameter int          CLK_MHZ     = 125,
    parameter int          REFRESH_NS  = 15000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stable,
    input  logic              suspend,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              bus_own,
    output logic              init_done,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    localparam int REFI   = CLK_MHZ * REFRESH_NS / 1000;
    localparam int MAX_A  = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int MAX_B  = (T_MRD > T_XSR) ? T_MRD : T_XSR;
    localparam int MAXW   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int WAIT_W = $clog2(MAXW + 1);
    localparam int REF_W  = $clog2(INIT_REFS + 1);

    typedef struct packed {
        state_e              state;
        phase_e              phase;
        logic [WAIT_W-1:0]   wt;
        logic [REF_W-1:0]    refs;
        cmd_e                cmd;
        logic                cke;
        logic                req;
        logic                own;
        logic                done;
    } seq_t;

    seq_t r_q, r_d;
    logic rfsh_pend;
    logic rfsh_clr;

    sdr_rfsh_timer #(.INTERVAL(REFI)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.done),
        .clr   (rfsh_clr),
        .pend  (rfsh_pend)
    );

    always_comb begin
        r_d     = r_q;
        r_d.cmd = CMD_NOP;
        if (r_q.wt != '0) r_d.wt = r_q.wt - 1'b1;

        case (r_q.state)
            ST_CLKWAIT: begin
                if (clk_stable) begin
                    r_d.cke   = 1'b1;
                    r_d.cmd   = CMD_PRE;
                    r_d.wt    = WAIT_W'(T_RP - 1);
                    r_d.state = ST_AFTER_PRE;
                end
            end
            ST_AFTER_PRE: begin
                if (r_q.wt == '0) begin
                    r_d.cmd = CMD_REF;
                    if (r_q.phase == PH_SUSP) begin
                        r_d.cke   = 1'b0;
                        r_d.state = ST_SELF;
                    end else begin
                        r_d.wt    = WAIT_W'(T_RFC - 1);
                        r_d.refs  = REF_W'(r_q.refs + 1'b1);
                        r_d.state = ST_AFTER_REF;
                    end
                end
            end
            ST_AFTER_REF: begin
                if (r_q.wt == '0) begin
                    case (r_q.phase)
                        PH_INIT1: begin
                            if (r_q.refs == REF_W'(INIT_REFS)) begin
                                r_d.cmd   = CMD_MRS;
                                r_d.wt    = WAIT_W'(T_MRD - 1);
                                r_d.refs  = '0;
                                r_d.state = ST_AFTER_MRS;
                            end else begin
                                r_d.cmd  = CMD_REF;
                                r_d.wt   = WAIT_W'(T_RFC - 1);
                                r_d.refs = REF_W'(r_q.refs + 1'b1);
                            end
                        end
                        PH_INIT2: begin
                            if (r_q.refs == REF_W'(INIT_REFS)) begin
                                r_d.done  = 1'b1;
                                r_d.own   = 1'b0;
                                r_d.refs  = '0;
                                r_d.state = ST_IDLE;
                            end else begin
                                r_d.cmd  = CMD_REF;
                                r_d.wt   = WAIT_W'(T_RFC - 1);
                                r_d.refs = REF_W'(r_q.refs + 1'b1);
                            end
                        end
                        default: begin
                            r_d.req   = 1'b0;
                            r_d.own   = 1'b0;
                            r_d.refs  = '0;
                            r_d.state = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_AFTER_MRS: begin
                if (r_q.wt == '0) begin
                    r_d.phase = PH_INIT2;
                    r_d.cmd   = CMD_REF;
                    r_d.wt    = WAIT_W'(T_RFC - 1);
                    r_d.refs  = REF_W'(1);
                    r_d.state = ST_AFTER_REF;
                end
            end
            ST_IDLE: begin
                if (suspend || rfsh_pend) begin
                    r_d.req   = 1'b1;
                    r_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    r_d.own   = 1'b1;
                    r_d.phase = suspend ? PH_SUSP : PH_AUTO;
                    r_d.cmd   = CMD_PRE;
                    r_d.wt    = WAIT_W'(T_RP - 1);
                    r_d.state = ST_AFTER_PRE;
                end
            end
            ST_SELF: begin
                if (!suspend) begin
                    r_d.cke   = 1'b1;
                    r_d.phase = PH_EXIT;
                    r_d.wt    = WAIT_W'(T_XSR - 1);
                    r_d.state = ST_EXIT_WAIT;
                end
            end
            ST_EXIT_WAIT: begin
                if (r_q.wt == '0) begin
                    r_d.cmd   = CMD_REF;
                    r_d.wt    = WAIT_W'(T_RFC - 1);
                    r_d.state = ST_AFTER_REF;
                end
            end
            default: r_d.state = ST_CLKWAIT;
        endcase

        rfsh_clr = r_q.done && (r_d.cmd == CMD_REF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_CLKWAIT;
            r_q.phase <= PH_INIT1;
            r_q.wt    <= '0;
            r_q.refs  <= '0;
            r_q.cmd   <= CMD_NOP;
            r_q.cke   <= 1'b0;
            r_q.req   <= 1'b0;
            r_q.own   <= 1'b1;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    sdr_cmd_enc #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .PRE_ALL_BIT (PRE_ALL_BIT),
        .MODE_VALUE  (MODE_VALUE)
    ) i_enc (
        .cmd   (r_q.cmd),
        .own   (r_q.own),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .ba    (ba)
    );

    assign bus_req   = r_q.req;
    assign bus_own   = r_q.own;
    assign init_done = r_q.done;
    assign cke       = r_q.cke;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic suspend,
    input logic bus_gnt,
    input logic bus_req,
    input logic init_done,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n
);
    logic is_cmd;
    assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);

    a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !cke) |-> (ras_n && cas_n && we_n));

    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r4_no_req_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !bus_req);

    a_r6_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && is_cmd) |-> $past(bus_gnt));

    a_r7_sr_entry_is_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && $fell(cke)) |-> (!cs_n && !ras_n && !cas_n && we_n));

    a_r8_cke_low_needs_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !cke) |-> $past(suspend));
endmodule

bind sdr_init_refresh_seq sdr_seq_checker i_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .suspend   (suspend),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .init_done (init_done),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n)
);

// File: tb/test_sdr_init_refresh_seq.sv
module test_sdr_init_refresh_seq;
    localparam int AW = 13, BW = 2, PAB = 10, NREF = 8;
    localparam int TRP = 2, TRFC = 3, TMRD = 2, TXSR = 4;
    localparam int MHZ = 4, RNS = 15000;
    localparam int REFI = MHZ * RNS / 1000;
    localparam int unsigned MODE = 32'h0123;

    logic clk = 1'b0, rst_n = 1'b0, clk_stable = 1'b0, suspend = 1'b0, bus_gnt = 1'b0;
    logic bus_req, bus_own, init_done, cke, cs_n, ras_n, cas_n, we_n;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;

    always #4 clk = ~clk;

    sdr_init_refresh_seq #(
        .ADDR_W(AW), .BA_W(BW), .PRE_ALL_BIT(PAB), .MODE_VALUE(MODE),
        .INIT_REFS(NREF), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .T_XSR(TXSR), .CLK_MHZ(MHZ), .REFRESH_NS(RNS)
    ) i_sdr_init_refresh_seq (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .suspend(suspend),
        .bus_gnt(bus_gnt), .bus_req(bus_req), .bus_own(bus_own),
        .init_done(init_done), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_ev = 0, n_rise = 0, n_fall = 0;
    int ev_t[512];
    int ev_c[512];
    logic ev_k[512];
    logic [AW-1:0] ev_a[512];
    int rise_c[64];
    int fall_c[64];
    int done_c = 0, cke_rise_c = 0;
    int lat = 0, gcnt = 0;
    logic hold_gnt = 1'b0;
    logic prev_req = 1'b0, prev_done = 1'b0, prev_cke = 1'b0;
    bit finished = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // 1 precharge, 2 refresh, 3 mode set, 9 other
    function automatic int decode();
        if (cs_n || (ras_n && cas_n && we_n)) return 0;
        if (!ras_n && cas_n && !we_n) return 1;
        if (!ras_n && !cas_n && we_n) return 2;
        if (!ras_n && !cas_n && !we_n) return 3;
        return 9;
    endfunction

    always @(negedge clk) begin
        int c;
        cyc++;
        if (rst_n) begin
            c = decode();
            if (c != 0 && n_ev < 512) begin
                ev_t[n_ev] = c; ev_c[n_ev] = cyc; ev_k[n_ev] = cke; ev_a[n_ev] = addr;
                n_ev++;
                if (init_done && !bus_gnt) check(0, "R6 command without grant", 0, 1);
            end
            if (bus_req && !prev_req && n_rise < 64) begin rise_c[n_rise] = cyc; n_rise++; end
            if (!bus_req && prev_req && n_fall < 64) begin fall_c[n_fall] = cyc; n_fall++; end
            if (init_done && !prev_done) done_c = cyc;
            if (cke && !prev_cke) cke_rise_c = cyc;
        end
        prev_req = bus_req; prev_done = init_done; prev_cke = cke;
        if (!bus_req) begin bus_gnt = 1'b0; gcnt = 0; end
        else if (!bus_gnt && !hold_gnt) begin
            if (gcnt >= lat) bus_gnt = 1'b1; else gcnt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wait_done(input string rq);
        for (int i = 0; i < 2000 && !init_done; i++) tick(1);
        check(init_done, rq, init_done, 1);
    endtask

    task automatic wait_rise(input int target, input string rq);
        for (int i = 0; i < 4 * REFI && n_rise < target; i++) tick(1);
        check(n_rise >= target, rq, n_rise, target);
    endtask

    task automatic wait_fall(input int target, input string rq);
        for (int i = 0; i < 4 * REFI && n_fall < target; i++) tick(1);
        check(n_fall >= target, rq, n_fall, target);
    endtask

    task automatic check_init(input int b);
        for (int i = 0; i < 2 * NREF + 2; i++) begin
            int et, gap;
            et  = (i == 0) ? 1 : (i == NREF + 1) ? 3 : 2;
            check(ev_t[b+i] == et, "R2 init command order", ev_t[b+i], et);
            check(ev_k[b+i] == 1'b1, "R2 cke high during init", ev_k[b+i], 1);
            if (i > 0) begin
                gap = (i == 1) ? TRP : (i == NREF + 2) ? TMRD : TRFC;
                check(ev_c[b+i] - ev_c[b+i-1] == gap, "R2 init spacing",
                      ev_c[b+i] - ev_c[b+i-1], gap);
            end
        end
        check(ev_a[b][PAB] == 1'b1, "R2 precharge-all address bit", ev_a[b][PAB], 1);
        check(ev_a[b+NREF+1] == AW'(MODE), "R2 mode value", ev_a[b+NREF+1], MODE);
        check(n_ev == b + 2 * NREF + 2, "R2 init command count", n_ev - b, 2 * NREF + 2);
        check(done_c - ev_c[b+2*NREF+1] == TRFC, "R3 init_done timing",
              done_c - ev_c[b+2*NREF+1], TRFC);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int b, r0;
        tick(5);
        rst_n = 1'b1;
        tick(20);
        // R1: nothing issued before clock stable
        check(n_ev == 0, "R1 no command before clk_stable", n_ev, 0);
        check(cke == 1'b0, "R1 cke low", cke, 0);
        check(init_done == 1'b0, "R1 init_done low", init_done, 0);
        check(bus_req == 1'b0, "R1 no request", bus_req, 0);
        check(!cs_n && ras_n && cas_n && we_n, "R1 NOP encoding", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        clk_stable = 1'b1;
        wait_done("R3 init completes");
        check_init(0);
        check(n_rise == 0, "R4 no request during init", n_rise, 0);
        tick(1);
        check(cs_n == 1'b1 && bus_own == 1'b0, "R10 released bus deselected", cs_n, 1);

        // R5/R6: periodic refresh with swept grant latency
        for (int k = 0; k < 5; k++) begin
            lat = k;
            wait_rise(k + 1, "R5 refresh request");
            b = n_ev;
            if (k == 0) check(rise_c[0] - done_c == REFI + 1, "R5 first request",
                              rise_c[0] - done_c, REFI + 1);
            else check(rise_c[k] - rise_c[k-1] == REFI, "R5 request interval",
                       rise_c[k] - rise_c[k-1], REFI);
            wait_fall(k + 1, "R6 release");
            check(n_ev == b + 2, "R6 command count", n_ev - b, 2);
            check(ev_t[b] == 1 && ev_t[b+1] == 2, "R6 precharge then refresh",
                  ev_t[b] * 10 + ev_t[b+1], 12);
            check(ev_a[b][PAB] == 1'b1, "R6 precharge all banks", ev_a[b][PAB], 1);
            check(ev_c[b+1] - ev_c[b] == TRP, "R6 tRP", ev_c[b+1] - ev_c[b], TRP);
            check(fall_c[k] - ev_c[b+1] == TRFC, "R6 tRFC before release",
                  fall_c[k] - ev_c[b+1], TRFC);
        end

        // R6: grant withheld longer than a refresh period
        lat = 1;
        hold_gnt = 1'b1;
        wait_rise(6, "R6 withheld request");
        b = n_ev;
        tick(REFI + 10);
        check(n_ev == b, "R6 no command without grant", n_ev - b, 0);
        check(bus_req == 1'b1, "R6 request held", bus_req, 1);
        hold_gnt = 1'b0;
        wait_fall(6, "R6 late release");
        check(n_ev == b + 2 && ev_t[b] == 1 && ev_t[b+1] == 2, "R6 single refresh after grant",
              n_ev - b, 2);
        wait_rise(7, "R5 backlog request");
        wait_fall(7, "R5 backlog release");
        tick(3);

        // R7/R8: suspend in normal operation
        b = n_ev; r0 = n_rise;
        suspend = 1'b1;
        wait_rise(r0 + 1, "R7 suspend request");
        for (int i = 0; i < 100 && n_ev < b + 2; i++) tick(1);
        check(ev_t[b] == 1 && ev_t[b+1] == 2, "R7 precharge then self refresh",
              ev_t[b] * 10 + ev_t[b+1], 12);
        check(ev_k[b+1] == 1'b0, "R7 cke low with self refresh", ev_k[b+1], 0);
        check(ev_c[b+1] - ev_c[b] == TRP, "R7 tRP", ev_c[b+1] - ev_c[b], TRP);
        tick(100);
        check(n_ev == b + 2, "R7 quiet in self refresh", n_ev - b, 2);
        check(cke == 1'b0, "R7 cke held low", cke, 0);
        suspend = 1'b0;
        wait_fall(n_fall + 1, "R8 exit release");
        check(ev_t[b+2] == 2 && ev_k[b+2] == 1'b1, "R8 exit refresh with cke high",
              ev_t[b+2], 2);
        check(ev_c[b+2] - cke_rise_c == TXSR, "R8 exit delay", ev_c[b+2] - cke_rise_c, TXSR);
        check(fall_c[n_fall-1] - ev_c[b+2] == TRFC, "R8 tRFC before release",
              fall_c[n_fall-1] - ev_c[b+2], TRFC);

        // R9: second power-up with suspend held through init
        rst_n = 1'b0; clk_stable = 1'b0;
        tick(3);
        rst_n = 1'b1;
        suspend = 1'b1;
        b = n_ev; r0 = n_rise;
        tick(5);
        check(n_ev == b && cke == 1'b0, "R1 quiet after second reset", n_ev - b, 0);
        clk_stable = 1'b1;
        wait_done("R9 init completes under suspend");
        check_init(b);
        check(n_rise == r0, "R9 no request during init", n_rise - r0, 0);
        wait_rise(r0 + 1, "R9 suspend request");
        check(rise_c[r0] - done_c == 1, "R9 request follows init_done", rise_c[r0] - done_c, 1);
        for (int i = 0; i < 100 && n_ev < b + 2 * NREF + 4; i++) tick(1);
        check(ev_t[b+2*NREF+2] == 1 && ev_t[b+2*NREF+3] == 2 && ev_k[b+2*NREF+3] == 1'b0,
              "R9 self refresh entry", ev_t[b+2*NREF+3], 2);
        suspend = 1'b0;
        wait_fall(n_fall + 1, "R8 second exit");
        check(ev_c[b+2*NREF+4] - cke_rise_c == TXSR, "R8 second exit delay",
              ev_c[b+2*NREF+4] - cke_rise_c, TXSR);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule